// File: doc/BRIEF.md
# Shared LED and EEPROM Pin Controller

This block owns three board pins that do two jobs. In normal running each pin lights a status LED. While a serial EEPROM transfer is under way, the same pins carry the three Microwire signals instead. Pin 0 pairs the receive-activity LED with the EEPROM clock. Pin 1 pairs the transmit-activity LED with the EEPROM data-out line. Pin 2 pairs the link-status LED with the EEPROM data-in line. Each LED has its own polarity bit and its own function code. Receive and transmit events are single-cycle strobes, so each one is stretched to a fixed minimum on-time that the eye can see.

Pin 0 also tells the block whether an EEPROM is fitted. While reset is held the controller leaves every pin undriven, so a board pull resistor sets the level on pin 0. The block samples that level on the first clock edge after reset is released, and the result becomes a read-only detect bit. The bit keeps that value until the next reset.

Control is a three-state machine. `ST_HOLD` is the reset state: all pins float and pin 0 is sampled on leaving it. `ST_LED` drives the LED levels. `ST_SHARE` drives the EEPROM signals. The transitions are:
- `ST_HOLD`→`ST_LED`, always, on the first edge after reset is released.
- `ST_LED`→`ST_SHARE` on an edge where the access request is high.
- `ST_SHARE`→`ST_LED` on an edge where the request is low.
- Any state→`ST_HOLD` when reset is asserted (asynchronous).

Top module: `ledpin_ctrl`

## Requirements
- R1: In EEPROM mode, pin_out[0] follows ee_sk, pin_out[1] follows ee_do and pin_out[2] follows ee_di in the same cycle, and all three pin_oe bits are 1.
- R2: EEPROM mode begins on the first clock edge that samples ee_req high while in LED mode. It ends on the first edge that samples ee_req low, after which the pins show LED levels again.
- R3: A led_pol bit of 0 makes that LED active low: the pin is 0 when its indication is on and 1 when it is off. A led_pol bit of 1 inverts this, so the pin is 1 when the indication is on.
- R4: Function code 0 (led_fn[2i+1:2i]=2'b00) selects the pin's native indication: receive activity on pin 0, transmit activity on pin 1, and link_up on pin 2.
- R5: Function code 1 selects combined receive-or-transmit activity. Code 2 selects link_up. Code 3 holds the indication off.
- R6: On the first clock edge after rst_n goes high, ee_present takes the level of pad0_in: 1 when high, 0 when low.
- R7: After that edge, ee_present ignores pad0_in and keeps its value until rst_n is asserted again.
- R8: A rx_evt or tx_evt sampled high makes its activity indication on for exactly HOLD_CYC cycles, starting after that edge. A new event during that window restarts the full window.
- R9: While rst_n is low, and up to the first edge after its release, all pin_oe bits are 0.
- R10: An ee_req already high at reset release does not skip LED mode. The pins show LED levels for one cycle and switch to EEPROM mode on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_evt | input | 1 | Receive event strobe |
| tx_evt | input | 1 | Transmit event strobe |
| link_up | input | 1 | Link-good level |
| led_fn | input | 6 | Function code per LED, two bits per pin, pin i in bits 2i+1:2i |
| led_pol | input | 3 | Polarity per LED, 1 = active high |
| ee_req | input | 1 | EEPROM access in progress |
| ee_sk | input | 1 | EEPROM serial clock to drive on pin 0 |
| ee_do | input | 1 | EEPROM data-out signal to drive on pin 1 |
| ee_di | input | 1 | EEPROM data-in signal to drive on pin 2 |
| pad0_in | input | 1 | Level read back from pin 0 |
| pin_out | output | 3 | Drive value for each pin |
| pin_oe | output | 3 | Output enable for each pin |
| ee_present | output | 1 | Read-only EEPROM-detect bit |

## Verification
The hardest case to reach is an access request that is already high when reset is released. The pins must spend exactly one cycle in LED mode before they hand over to the EEPROM signals. The bench holds ee_req high across a full reset and checks the pins on the two cycles that follow. A second hard case is an activity event that arrives partway through a stretch window. The bench fires a second strobe two cycles into the window and then counts the full on-time again from that strobe.

// File: rtl/ledpin_pkg.sv
package ledpin_pkg;

    localparam int NUM_PINS = 3;
    localparam int FN_W     = 2;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_LED   = 2'd1,
        ST_SHARE = 2'd2
    } pin_state_e;

    typedef enum logic [1:0] {
        FN_NATIVE  = 2'd0,
        FN_ANY_ACT = 2'd1,
        FN_LINK    = 2'd2,
        FN_OFF     = 2'd3
    } led_fn_e;

endpackage

// File: rtl/ledpin_stretch.sv
module ledpin_stretch #(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic active
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC);

    logic [CW-1:0] remain;

    // Each event reloads the full window; otherwise count down to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (evt) begin
            remain <= RELOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign active = (remain != '0);
endmodule

// File: rtl/ledpin_sel.sv
module ledpin_sel
    import ledpin_pkg::*;
#(
    parameter int PINS = NUM_PINS
) (
    input  logic              rx_act,
    input  logic              tx_act,
    input  logic              link_up,
    input  logic [PINS*FN_W-1:0] led_fn,
    input  logic [PINS-1:0]   led_pol,
    output logic [PINS-1:0]   led_lvl
);
    logic [PINS-1:0] native;
    logic [PINS-1:0] ind;

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        // Native indication depends on the pin position
        if (i == 0) begin : g_rx
            assign native[i] = rx_act;
        end else if (i == 1) begin : g_tx
            assign native[i] = tx_act;
        end else begin : g_link
            assign native[i] = link_up;
        end

        always_comb begin
            unique case (led_fn_e'(led_fn[i*FN_W +: FN_W]))
                FN_NATIVE:  ind[i] = native[i];
                FN_ANY_ACT: ind[i] = rx_act | tx_act;
                FN_LINK:    ind[i] = link_up;
                FN_OFF:     ind[i] = 1'b0;
                default:    ind[i] = 1'b0;
            endcase
        end

        // Polarity 0: active low; polarity 1: active high
        assign led_lvl[i] = led_pol[i] ? ind[i] : ~ind[i];
    end
endmodule

// File: rtl/ledpin_fsm.sv
module ledpin_fsm
    import ledpin_pkg::*;
#(
    parameter int PINS = NUM_PINS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ee_req,
    input  logic            pad0_in,
    input  logic [PINS-1:0] led_lvl,
    input  logic [PINS-1:0] ee_lvl,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_oe,
    output logic            ee_present
);
    pin_state_e state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD:  state_nx = ST_LED;
            ST_LED:   state_nx = ee_req ? ST_SHARE : ST_LED;
            ST_SHARE: state_nx = ee_req ? ST_SHARE : ST_LED;
            default:  state_nx = ST_HOLD;
        endcase
    end

    // Detect bit: captured only on leaving the reset state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ee_present <= 1'b0;
        end else if (state == ST_HOLD) begin
            ee_present <= pad0_in;
        end
    end

    // Pin drive per state
    always_comb begin
        pin_out = led_lvl;
        pin_oe  = '0;
        unique case (state)
            ST_HOLD: begin
                pin_out = led_lvl;
                pin_oe  = '0;
            end
            ST_LED: begin
                pin_out = led_lvl;
                pin_oe  = '1;
            end
            ST_SHARE: begin
                pin_out = ee_lvl;
                pin_oe  = '1;
            end
            default: begin
                pin_out = led_lvl;
                pin_oe  = '0;
            end
        endcase
    end
endmodule

// File: rtl/ledpin_ctrl.sv
module ledpin_ctrl
    import ledpin_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_evt,
    input  logic                     tx_evt,
    input  logic                     link_up,
    input  logic [NUM_PINS*FN_W-1:0] led_fn,
    input  logic [NUM_PINS-1:0]      led_pol,
    input  logic                     ee_req,
    input  logic                     ee_sk,
    input  logic                     ee_do,
    input  logic                     ee_di,
    input  logic                     pad0_in,
    output logic [NUM_PINS-1:0]      pin_out,
    output logic [NUM_PINS-1:0]      pin_oe,
    output logic                     ee_present
);
    logic rx_act, tx_act;
    logic [NUM_PINS-1:0] led_lvl;
    logic [NUM_PINS-1:0] ee_lvl;

    assign ee_lvl = {ee_di, ee_do, ee_sk};

    ledpin_stretch #(.HOLD_CYC(HOLD_CYC)) u_rx_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (rx_evt),
        .active (rx_act)
    );

    ledpin_stretch #(.HOLD_CYC(HOLD_CYC)) u_tx_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (tx_evt),
        .active (tx_act)
    );

    ledpin_sel #(.PINS(NUM_PINS)) u_sel (
        .rx_act  (rx_act),
        .tx_act  (tx_act),
        .link_up (link_up),
        .led_fn  (led_fn),
        .led_pol (led_pol),
        .led_lvl (led_lvl)
    );

    ledpin_fsm #(.PINS(NUM_PINS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ee_req     (ee_req),
        .pad0_in    (pad0_in),
        .led_lvl    (led_lvl),
        .ee_lvl     (ee_lvl),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .ee_present (ee_present)
    );
endmodule

// File: rtl/ledpin_ctrl_chk.sv
module ledpin_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_evt,
    input logic [5:0] led_fn,
    input logic [2:0] led_pol,
    input logic       ee_req,
    input logic       ee_sk,
    input logic       ee_do,
    input logic       ee_di,
    input logic       pad0_in,
    input logic [2:0] pin_out,
    input logic [2:0] pin_oe,
    input logic       ee_present
);
    // Cycles since reset release, saturating at 2
    logic [1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 2'd0;
        end else if (run != 2'd2) begin
            run <= run + 2'd1;
        end
    end

    // R1 / R2: a request seen on the previous edge puts the EEPROM signals on the pins
    p_ee_mux_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run == 2'd2 && $past(ee_req)) |-> (pin_out == {ee_di, ee_do, ee_sk} && pin_oe == 3'b111));

    // R9: pins still float at the first edge after release
    p_float_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == 3'b000));

    // R6: detect bit takes the pad level seen at the release edge
    p_detect_sample_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |=> (ee_present == $past(pad0_in)));

    // R7: detect bit stays fixed after it has been sampled
    p_detect_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run != 2'd0) |=> $stable(ee_present));

    // R8 / R3: a receive strobe lights the default active-low pin 0 on the next cycle
    p_stretch_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run == 2'd2 && !$past(ee_req) && $past(rx_evt) && led_fn[1:0] == 2'b00
         && !led_pol[0]) |-> (pin_out[0] == 1'b0));

    // R10: after release, pins are driven from the second edge on
    p_driven_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run == 2'd2) |-> (pin_oe == 3'b111));
endmodule

bind ledpin_ctrl ledpin_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_evt     (rx_evt),
    .led_fn     (led_fn),
    .led_pol    (led_pol),
    .ee_req     (ee_req),
    .ee_sk      (ee_sk),
    .ee_do      (ee_do),
    .ee_di      (ee_di),
    .pad0_in    (pad0_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .ee_present (ee_present)
);

// File: tb/ledpin_ctrl_bench.sv
module ledpin_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_evt = 1'b0, tx_evt = 1'b0, link_up = 1'b0;
    logic [5:0] led_fn = 6'b0;
    logic [2:0] led_pol = 3'b0;
    logic       ee_req = 1'b0, ee_sk = 1'b0, ee_do = 1'b0, ee_di = 1'b0;
    logic       pad0_in = 1'b0;
    logic [2:0] pin_out, pin_oe;
    logic       ee_present;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ledpin_ctrl #(.HOLD_CYC(HOLD)) u_ledpin_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt), .link_up(link_up),
        .led_fn(led_fn), .led_pol(led_pol), .ee_req(ee_req), .ee_sk(ee_sk),
        .ee_do(ee_do), .ee_di(ee_di), .pad0_in(pad0_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .ee_present(ee_present)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic pad);
        @(negedge clk);
        rst_n = 1'b0;
        pad0_in = pad;
        repeat (3) @(negedge clk);
        chk(pin_oe == 3'b000, "R9 oe in reset", int'(pin_oe), 0);
        rst_n = 1'b1;
        chk(pin_oe == 3'b000, "R9 oe before first edge", int'(pin_oe), 0);
        @(negedge clk);
        chk(ee_present == pad, "R6 detect sample", int'(ee_present), int'(pad));
        chk(pin_oe == 3'b111, "R9 oe after release", int'(pin_oe), 7);
    endtask

    task automatic t_detect;
        do_reset(1'b1);
        pad0_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(ee_present == 1'b1, "R7 detect hold high", int'(ee_present), 1);
        do_reset(1'b0);
        pad0_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(ee_present == 1'b0, "R7 detect hold low", int'(ee_present), 0);
    endtask

    task automatic t_defaults;
        led_fn = 6'b0; led_pol = 3'b0; link_up = 1'b0;
        @(negedge clk);
        chk(pin_out == 3'b111, "R3 idle active-low", int'(pin_out), 7);
        link_up = 1'b1;
        #1;
        chk(pin_out == 3'b011, "R4 link on pin2", int'(pin_out), 3);
        link_up = 1'b0;
        tx_evt = 1'b1;
        @(negedge clk);
        tx_evt = 1'b0;
        chk(pin_out == 3'b101, "R4 tx on pin1", int'(pin_out), 5);
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic t_stretch;
        rx_evt = 1'b1;
        @(negedge clk);
        rx_evt = 1'b0;
        for (int k = 0; k < HOLD; k++) begin
            chk(pin_out[0] == 1'b0, "R8 stretch on", int'(pin_out[0]), 0);
            @(negedge clk);
        end
        chk(pin_out[0] == 1'b1, "R8 stretch end", int'(pin_out[0]), 1);
        // retrigger two cycles into the window
        rx_evt = 1'b1;
        @(negedge clk);
        rx_evt = 1'b0;
        @(negedge clk);
        rx_evt = 1'b1;
        @(negedge clk);
        rx_evt = 1'b0;
        for (int k = 0; k < HOLD; k++) begin
            chk(pin_out[0] == 1'b0, "R8 retrigger on", int'(pin_out[0]), 0);
            @(negedge clk);
        end
        chk(pin_out[0] == 1'b1, "R8 retrigger end", int'(pin_out[0]), 1);
    endtask

    task automatic t_polarity;
        led_pol = 3'b100; link_up = 1'b1;
        #1;
        chk(pin_out[2] == 1'b1, "R3 active-high on", int'(pin_out[2]), 1);
        link_up = 1'b0;
        #1;
        chk(pin_out[2] == 1'b0, "R3 active-high off", int'(pin_out[2]), 0);
        led_pol = 3'b000;
        @(negedge clk);
    endtask

    task automatic t_fn_codes;
        // pin0 code2 link, pin1 code1 any activity, pin2 code3 off
        led_fn = {2'd3, 2'd1, 2'd2};
        link_up = 1'b1;
        #1;
        chk(pin_out[0] == 1'b0, "R5 code2 link", int'(pin_out[0]), 0);
        chk(pin_out[2] == 1'b1, "R5 code3 off", int'(pin_out[2]), 1);
        chk(pin_out[1] == 1'b1, "R5 code1 idle", int'(pin_out[1]), 1);
        rx_evt = 1'b1;
        @(negedge clk);
        rx_evt = 1'b0;
        chk(pin_out[1] == 1'b0, "R5 code1 rx", int'(pin_out[1]), 0);
        link_up = 1'b0;
        led_fn = 6'b0;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic t_ee_mode;
        ee_req = 1'b1; ee_sk = 1'b1; ee_do = 1'b0; ee_di = 1'b1;
        #1;
        chk(pin_out == 3'b111, "R2 not yet shared", int'(pin_out), 7);
        @(negedge clk);
        chk(pin_out == 3'b101, "R1 shared pins", int'(pin_out), 5);
        chk(pin_oe == 3'b111, "R1 shared oe", int'(pin_oe), 7);
        ee_sk = 1'b0; ee_do = 1'b1;
        #1;
        chk(pin_out == 3'b110, "R1 follow signals", int'(pin_out), 6);
        ee_req = 1'b0;
        #1;
        chk(pin_out == 3'b110, "R2 exit waits edge", int'(pin_out), 6);
        @(negedge clk);
        chk(pin_out == 3'b111, "R2 back to LED", int'(pin_out), 7);
    endtask

    task automatic t_req_at_release;
        @(negedge clk);
        rst_n = 1'b0;
        pad0_in = 1'b1;
        ee_req = 1'b1; ee_sk = 1'b0; ee_do = 1'b0; ee_di = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin_out == 3'b111, "R10 LED first", int'(pin_out), 7);
        @(negedge clk);
        chk(pin_out == 3'b000, "R10 shared second", int'(pin_out), 0);
        ee_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        t_detect();
        t_defaults();
        t_stretch();
        t_polarity();
        t_fn_codes();
        t_ee_mode();
        t_req_at_release();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule